// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting ticks. Software must strobe `clear` inside an open window at the end of each watchdog period. A strobe that never arrives lets the count run through the whole period, and the block raises a reset request. A strobe that arrives before the window opens is treated as a fault of equal weight and also raises a reset request. The early-clear rule catches code that is stuck in a tight loop which keeps clearing the watchdog.

The period is `BASE_TICKS << period_sel` ticks. The open window covers the last `(window_sel+1)/8` of that period, so it can be set from one eighth of the period up to the whole period. At the whole period, any clear is accepted. Each reset request is a single-cycle pulse. A flag beside it records which fault caused the most recent request. Both select inputs are captured only when the count restarts, so a change made in the middle of a period does not alter that period.

Top module: `winwdt_top`

## Requirements
- R1: While `rst_n` is low, `rst_req` and `cause_early` are 0 and the count is held at zero. A timeout therefore needs a full period after the block is enabled.
- R2: With `enable` high and no clear, `rst_req` is raised after exactly P ticks, where P = `BASE_TICKS << period_sel`. The pulse appears in the cycle after the edge that samples the P-th tick.
- R3: A clear sampled while the count is below the window opening point raises `rst_req` and sets `cause_early` to 1.
- R4: The window opens at count P*(7-w)/8, where w is the value of `window_sel`. A clear sampled at a count at or above that point is accepted and raises no reset request. An accepted clear sets the count to zero.
- R5: With `window_sel` = 7, a clear at any count, including count 0, is accepted.
- R6: `rst_req` stays high for exactly one cycle. The count then restarts from zero, and the next timeout comes a full period later.
- R7: `cause_early` is 0 after a timeout and 1 after an early clear. It keeps its value through accepted clears until the next reset request.
- R8: `period_sel` and `window_sel` are captured only when the count restarts (accepted clear, reset request, or while `enable` is low). A change made in the middle of a period affects only the next period.
- R9: While `enable` is low, the count is held at zero, `clear` is ignored, and `rst_req` stays 0.
- R10: The count advances only in cycles where `tick` is high. With `tick` low, no timeout ever occurs.
- R11: A clear that arrives in the same cycle as the final tick of the period is an accepted clear when the window is open. No reset request is raised, and a new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one tick per high cycle |
| enable | input | 1 | Watchdog on |
| period_sel | input | PSEL_W | Period code; P = BASE_TICKS << code |
| window_sel | input | 3 | Window code w; window is (w+1)/8 of P |
| clear | input | 1 | Software clear strobe |
| rst_req | output | 1 | Single-cycle reset request |
| cause_early | output | 1 | 1: last request from an early clear; 0: from a timeout |

## Verification
A clear and the final tick of a period can fall in the same cycle. In that case the block must decide between a timeout and an accepted clear. The bench provokes this by holding `tick` high and strobing `clear` when the count reaches P-1 with a 25% window. It then judges that no reset request appears in that cycle, and that the next timeout comes a full period later. The bench also pairs an early clear with an active tick and expects an early-clear fault rather than a plain count advance.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

  localparam int WSEL_W = 3;

  typedef enum logic {
    CAUSE_TIMEOUT = 1'b0,
    CAUSE_EARLY   = 1'b1
  } cause_e;

endpackage

// File: rtl/winwdt_cfg.sv
module winwdt_cfg
  import winwdt_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int PSEL_W     = 2,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PSEL_W-1:0] period_sel,
  input  logic [WSEL_W-1:0] window_sel,
  output logic [CNT_W-1:0]  period_q,
  output logic [CNT_W-1:0]  open_q
);
  localparam int NPER = 1 << PSEL_W;

  logic [CNT_W-1:0]  per_tab [NPER];
  logic [PSEL_W-1:0] psel_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [CNT_W-1:0]  eighth;
  logic [CNT_W-1:0]  closed_parts;

  for (genvar g = 0; g < NPER; g++) begin : g_per
    assign per_tab[g] = CNT_W'(BASE_TICKS << g);
  end

  // selects are captured only on a restart of the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_q <= '0;
      wsel_q <= '1;
    end else if (load) begin
      psel_q <= period_sel;
      wsel_q <= window_sel;
    end
  end

  always_comb begin
    period_q     = per_tab[psel_q];
    eighth       = period_q >> 3;
    closed_parts = CNT_W'(3'd7 - wsel_q);
    open_q       = eighth * closed_parts;
  end

  // window opening point always lies inside the period
  assert_open_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    open_q < period_q);

endmodule

// File: rtl/winwdt_ctr.sv
module winwdt_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (hold || restart)  cnt <= '0;
    else if (tick)             cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == period_q - 1'b1);

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  assert_stall_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !hold) |=> $stable(cnt));

  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

endmodule

// File: rtl/winwdt_judge.sv
module winwdt_judge
  import winwdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             tick,
  input  logic             at_last,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] open_q,
  output logic             restart,
  output logic             rst_req,
  output logic             cause_early
);
  logic   clr_ok, clr_early, tmo, fault;
  cause_e cause_q;

  always_comb begin
    clr_ok    = enable && clear && (cnt >= open_q);
    clr_early = enable && clear && (cnt <  open_q);
    // a clear in the same cycle overrides the final tick
    tmo       = enable && tick && at_last && !clear;
    fault     = clr_early || tmo;
    restart   = fault || clr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      cause_q <= CAUSE_TIMEOUT;
    end else begin
      rst_req <= fault;
      if (clr_early)  cause_q <= CAUSE_EARLY;
      else if (tmo)   cause_q <= CAUSE_TIMEOUT;
    end
  end

  assign cause_early = (cause_q == CAUSE_EARLY);

  assert_early_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_early |=> (rst_req && cause_early));

  assert_inwindow_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> !rst_req);

endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int PSEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic [PSEL_W-1:0] period_sel,
  input  logic [2:0]        window_sel,
  input  logic              clear,
  output logic              rst_req,
  output logic              cause_early
);
  localparam int MAX_PERIOD = BASE_TICKS << ((1 << PSEL_W) - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD) + 1;

  logic [CNT_W-1:0] period_q, open_q, cnt;
  logic             at_last, restart;

  winwdt_cfg #(.BASE_TICKS(BASE_TICKS), .PSEL_W(PSEL_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(restart || !enable),
    .period_sel(period_sel), .window_sel(window_sel),
    .period_q(period_q), .open_q(open_q));

  winwdt_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .hold(!enable), .restart(restart), .tick(tick),
    .period_q(period_q), .cnt(cnt), .at_last(at_last));

  winwdt_judge #(.CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear), .tick(tick),
    .at_last(at_last), .cnt(cnt), .open_q(open_q), .restart(restart),
    .rst_req(rst_req), .cause_early(cause_early));

  assert_req_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rst_req);

  assert_cause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |-> $stable(cause_early));

endmodule

// File: tb/sim_winwdt_top.sv
module sim_winwdt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       enable = 1'b0;
  logic [1:0] period_sel = 2'd0;
  logic [2:0] window_sel = 3'd7;
  logic       clear = 1'b0;
  logic       rst_req, cause_early;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  winwdt_top #(.BASE_TICKS(16), .PSEL_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .period_sel(period_sel), .window_sel(window_sel), .clear(clear),
    .rst_req(rst_req), .cause_early(cause_early));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // disable, load selects, enable; afterwards count is zero
  task automatic start(input logic [1:0] ps, input logic [2:0] ws);
    @(negedge clk);
    enable = 1'b0; period_sel = ps; window_sel = ws; clear = 1'b0; tick = 1'b1;
    @(negedge clk);
    enable = 1'b1;
  endtask

  // edges until rst_req seen (0 when none within lim)
  task automatic edges_to_req(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (rst_req) begin n = i; return; end
    end
  endtask

  // wait m edges (count = m), then strobe clear; returns rst_req after it
  task automatic clear_at(input int m, output logic req);
    repeat (m) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    req = rst_req;
  endtask

  task automatic t_reset();
    check("R1 rst_req in reset", rst_req, 0);
    check("R1 cause in reset", cause_early, 0);
  endtask

  task automatic t_periods();
    int n;
    for (int p = 0; p < 4; p++) begin
      start(2'(p), 3'd7);
      edges_to_req(300, n);
      check($sformatf("R2 timeout ps=%0d", p), n, 16 << p);
      if (p == 0) check("R1 first timeout after full period", n, 16);
      check("R7 cause after timeout", cause_early, 0);
      @(negedge clk);
      check("R6 pulse one cycle", rst_req, 0);
      edges_to_req(300, n);
      check("R6 next timeout full period", n, (16 << p) - 1);
    end
  endtask

  task automatic t_window();
    logic r; int n;
    start(2'd0, 3'd1);                       // open at 12
    clear_at(11, r);
    check("R3 early clear at 11 requests", r, 1);
    check("R3 cause early", cause_early, 1);
    check("R7 cause early set", cause_early, 1);
    clear_at(12, r);                          // count restarted from zero
    check("R4 clear at 12 accepted", r, 0);
    check("R7 cause held after valid clear", cause_early, 1);
    edges_to_req(100, n);
    check("R4 valid clear restarts count", n, 16);
    check("R7 timeout clears cause", cause_early, 0);
  endtask

  task automatic t_full_window();
    logic r;
    start(2'd0, 3'd7);
    clear_at(0, r);
    check("R5 clear at count 0 accepted", r, 0);
    clear_at(1, r);
    check("R5 clear at count 1 accepted", r, 0);
  endtask

  task automatic t_cfg_change();
    logic r; int n;
    start(2'd0, 3'd1);
    repeat (3) @(negedge clk);
    window_sel = 3'd7; period_sel = 2'd1;
    clear_at(2, r);                           // count 5 < 12 under old window
    check("R8 old window still applied", r, 1);
    check("R8 early cause", cause_early, 1);
    clear_at(0, r);                           // new window 7 now in force
    check("R8 new window after restart", r, 0);
    edges_to_req(200, n);
    check("R8 new period after restart", n, 32);
  endtask

  task automatic t_disabled();
    int n;
    @(negedge clk);
    enable = 1'b0; period_sel = 2'd0; window_sel = 3'd0;
    for (int i = 0; i < 60; i++) begin
      clear = (i % 5 == 0);
      @(negedge clk);
      if (rst_req) n = -1;
    end
    clear = 1'b0;
    check("R9 cause untouched while disabled", cause_early, 0);
    enable = 1'b1;
    edges_to_req(100, n);
    check("R9 count held at zero while disabled", n, 16);
  endtask

  task automatic t_tick();
    int n;
    start(2'd0, 3'd7);
    tick = 1'b0;
    edges_to_req(80, n);
    check("R10 no timeout without ticks", n, 0);
    tick = 1'b1;
    edges_to_req(100, n);
    check("R10 timeout counts ticks only", n, 16);
  endtask

  task automatic t_same_cycle();
    logic r; int n;
    start(2'd0, 3'd1);
    clear_at(15, r);                          // final tick and clear together
    check("R11 clear wins over final tick", r, 0);
    edges_to_req(100, n);
    check("R11 new period after combined cycle", n, 16);
    clear_at(3, r);                           // early clear with active tick
    check("R11 early clear with tick requests", r, 1);
    check("R11 early cause with tick", cause_early, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_periods();
    t_window();
    t_full_window();
    t_cfg_change();
    t_disabled();
    t_tick();
    t_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule